// File: doc/BRIEF.md
# Clocked Pulse Handshake Monitor

This block is a synthesizable observer for a channel on which every handshake event is a one-cycle pulse on a dedicated wire. A high level on a wire in a given clock cycle means one event happened on that wire in that cycle. The monitor drives nothing onto the channel. It watches the wires and reports the first breach of the clocked protocol that it sees.

One parameter picks the kind of channel:
- **Control**: a request wire and an acknowledge wire.
- **Read**: a request wire and a dual-rail answer on two wires, one for value 0 and one for value 1.
- **Write**: a dual-rail request on two value wires and an acknowledge wire. A read strobe on the same variable is also observed.

The monitor raises a sticky error flag and latches a 3-bit code for the first violation. A busy output shows that a control or write handshake is outstanding. A designer places one instance on each channel that needs checking. The flag then stays visible until the next reset.

Top module: `hsmon_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy_o`, `err_flag_o` and `err_code_o` are all 0.
- R2: Control and write channels: an acknowledge in the same cycle as a request, while no handshake is outstanding, sets the error with code 1 (early acknowledge) in the next cycle.
- R3: An answer that arrives with no request outstanding and no request in the same cycle sets the error with code 2 (unsolicited acknowledge). This covers `ack_i` on control and write channels, and `ack0_i` or `ack1_i` on read channels.
- R4: Control and write channels: a request while a handshake is outstanding, with no acknowledge in that cycle, sets code 3 (repeated request).
- R5: Control and write channels: `busy_o` rises in the cycle after a legal request and falls in the cycle after its acknowledge. An acknowledge together with a new request, while busy, is legal and keeps `busy_o` high.
- R6: Read channels: a request with exactly one of `ack0_i`/`ack1_i` in the same cycle is legal. A request with both answer wires sets code 4. A request with neither answer wire sets code 6 (missing answer). `busy_o` stays 0.
- R7: Write channels: `req0_i` and `req1_i` high in the same cycle sets code 4 (dual-rail conflict).
- R8: Write channels: `rd_i` high in the same cycle as `ack_i` sets code 5 (read after write in the same period).
- R9: The error flag stays set until reset, and the code holds the first violation seen. When several violations occur in one cycle, the smallest code is recorded.
- R10: Inputs that the selected channel kind does not use have no effect on any output:
  - control uses `req_i` and `ack_i`;
  - read uses `req_i`, `ack0_i` and `ack1_i`;
  - write uses `req0_i`, `req1_i`, `ack_i` and `rd_i`.
- R11: A legal sequence of handshakes leaves `err_flag_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse (control, read) |
| req0_i | input | 1 | Write request carrying value 0 |
| req1_i | input | 1 | Write request carrying value 1 |
| ack_i | input | 1 | Acknowledge pulse (control, write) |
| ack0_i | input | 1 | Read answer: value 0 |
| ack1_i | input | 1 | Read answer: value 1 |
| rd_i | input | 1 | Read strobe on the written variable (write) |
| busy_o | output | 1 | Handshake outstanding |
| err_flag_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of the first violation, 0 when none |

## Verification
The hardest case to reach is a cycle in which two violations land together, or in which a later violation with a smaller code follows a first one. Only that case shows whether the first error is kept and whether the ordering inside one cycle is right. The stimulus builds two-cycle scenarios that stack an early acknowledge with a stray acknowledge, or that assert both read rails without a request. A directed run then injects a smaller-coded violation several cycles after the first, with legal traffic in between.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;

  typedef enum logic [1:0] {
    CH_CTRL  = 2'd0,
    CH_READ  = 2'd1,
    CH_WRITE = 2'd2
  } chan_kind_e;

  localparam int NCODE  = 6;
  localparam int CODE_W = $clog2(NCODE + 1);

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE   = 3'd0,
    ERR_EARLY  = 3'd1,
    ERR_UNSOL  = 3'd2,
    ERR_REPEAT = 3'd3,
    ERR_RAIL   = 3'd4,
    ERR_RAW    = 3'd5,
    ERR_NORESP = 3'd6
  } err_code_e;

endpackage

// File: rtl/hsmon_classify.sv
module hsmon_classify
  import hsmon_pkg::*;
#(
  parameter chan_kind_e KIND = CH_CTRL
) (
  input  logic             req_i,
  input  logic             req0_i,
  input  logic             req1_i,
  input  logic             ack_i,
  input  logic             ack0_i,
  input  logic             ack1_i,
  input  logic             rd_i,
  input  logic             busy_q_i,
  output logic [NCODE-1:0] viol_o,
  output logic             busy_d_o
);

  // bit k of viol_o stands for code k+1
  localparam int B_EARLY  = int'(ERR_EARLY) - 1;
  localparam int B_UNSOL  = int'(ERR_UNSOL) - 1;
  localparam int B_REPEAT = int'(ERR_REPEAT) - 1;
  localparam int B_RAIL   = int'(ERR_RAIL) - 1;
  localparam int B_RAW    = int'(ERR_RAW) - 1;
  localparam int B_NORESP = int'(ERR_NORESP) - 1;

  generate
    if (KIND == CH_READ) begin : g_read
      logic any_ans;
      logic unused_in;
      assign unused_in = ^{req0_i, req1_i, ack_i, rd_i, busy_q_i};
      assign any_ans   = ack0_i | ack1_i;
      always_comb begin
        viol_o           = '0;
        viol_o[B_RAIL]   = ack0_i & ack1_i;
        viol_o[B_UNSOL]  = any_ans & ~req_i;
        viol_o[B_NORESP] = req_i & ~any_ans;
        busy_d_o         = 1'b0;
      end
    end else if (KIND == CH_WRITE) begin : g_write
      logic wreq;
      logic unused_in;
      assign unused_in = ^{req_i, ack0_i, ack1_i};
      assign wreq      = req0_i | req1_i;
      always_comb begin
        viol_o           = '0;
        viol_o[B_RAIL]   = req0_i & req1_i;
        viol_o[B_EARLY]  = ack_i & wreq & ~busy_q_i;
        viol_o[B_UNSOL]  = ack_i & ~wreq & ~busy_q_i;
        viol_o[B_REPEAT] = wreq & busy_q_i & ~ack_i;
        viol_o[B_RAW]    = ack_i & rd_i;
        busy_d_o         = busy_q_i ? (~ack_i | wreq) : (wreq & ~ack_i);
      end
    end else begin : g_ctrl
      logic unused_in;
      assign unused_in = ^{req0_i, req1_i, ack0_i, ack1_i, rd_i};
      always_comb begin
        viol_o           = '0;
        viol_o[B_EARLY]  = ack_i & req_i & ~busy_q_i;
        viol_o[B_UNSOL]  = ack_i & ~req_i & ~busy_q_i;
        viol_o[B_REPEAT] = req_i & busy_q_i & ~ack_i;
        busy_d_o         = busy_q_i ? (~ack_i | req_i) : (req_i & ~ack_i);
      end
    end
  endgenerate

endmodule

// File: rtl/hsmon_pick.sv
module hsmon_pick #(
  parameter int N = 6,
  parameter int W = 3
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] code_o,
  output logic         any_o
);

  // lowest set bit wins; the code is its index plus one
  always_comb begin
    code_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) code_o = W'(k + 1);
    end
  end

  assign any_o = |vec_i;

endmodule

// File: rtl/hsmon_sticky.sv
module hsmon_sticky #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  logic [W-1:0] code_i,
  output logic         flag_o,
  output logic [W-1:0] code_o
);

  logic         flag_q, flag_d;
  logic [W-1:0] code_q, code_d;
  logic         cap_en;

  assign cap_en = hit_i & ~flag_q;

  always_comb begin
    flag_d = flag_q | hit_i;
    code_d = cap_en ? code_i : code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (cap_en) begin
      flag_q <= flag_d;
      code_q <= code_d;
    end
  end

  assign flag_o = flag_q;
  assign code_o = code_q;

endmodule

// File: rtl/hsmon_top.sv
module hsmon_top
  import hsmon_pkg::*;
#(
  parameter chan_kind_e KIND = CH_CTRL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req0_i,
  input  logic              req1_i,
  input  logic              ack_i,
  input  logic              ack0_i,
  input  logic              ack1_i,
  input  logic              rd_i,
  output logic              busy_o,
  output logic              err_flag_o,
  output logic [CODE_W-1:0] err_code_o
);

  logic             busy_q, busy_d, busy_en;
  logic [NCODE-1:0] viol;
  logic [CODE_W-1:0] first_code;
  logic             any_viol;

  hsmon_classify #(.KIND(KIND)) u_class (
    .req_i    (req_i),
    .req0_i   (req0_i),
    .req1_i   (req1_i),
    .ack_i    (ack_i),
    .ack0_i   (ack0_i),
    .ack1_i   (ack1_i),
    .rd_i     (rd_i),
    .busy_q_i (busy_q),
    .viol_o   (viol),
    .busy_d_o (busy_d)
  );

  hsmon_pick #(.N(NCODE), .W(CODE_W)) u_pick (
    .vec_i  (viol),
    .code_o (first_code),
    .any_o  (any_viol)
  );

  hsmon_sticky #(.W(CODE_W)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (any_viol),
    .code_i (first_code),
    .flag_o (err_flag_o),
    .code_o (err_code_o)
  );

  assign busy_en = busy_d ^ busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/hsmon_chk.sv
module hsmon_chk
  import hsmon_pkg::*;
#(
  parameter chan_kind_e KIND = CH_CTRL
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              req0_i,
  input logic              req1_i,
  input logic              ack_i,
  input logic              ack0_i,
  input logic              ack1_i,
  input logic              rd_i,
  input logic              busy_o,
  input logic              err_flag_o,
  input logic [CODE_W-1:0] err_code_o
);

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && !err_flag_o && err_code_o == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |=> err_flag_o);

  assert_code_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |=> $stable(err_code_o));

  assert_code_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_flag_o |-> err_code_o == '0);

  generate
    if (KIND == CH_READ) begin : g_read
      logic unused_in;
      assign unused_in = ^{req0_i, req1_i, ack_i, rd_i};

      assert_never_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o);
      assert_rail_clash_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack0_i && ack1_i) |=> err_flag_o);
      assert_no_answer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !ack0_i && !ack1_i) |=> err_flag_o);
    end else begin : g_hs
      logic wreq;
      logic unused_in;
      if (KIND == CH_WRITE) begin : g_w
        assign wreq      = req0_i | req1_i;
        assign unused_in = ^{req_i, ack0_i, ack1_i};
        assert_rail_clash_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (req0_i && req1_i) |=> err_flag_o);
        assert_read_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (ack_i && rd_i) |=> err_flag_o);
      end else begin : g_c
        assign wreq      = req_i;
        assign unused_in = ^{req0_i, req1_i, ack0_i, ack1_i, rd_i};
      end

      // an idle acknowledge is either early (R2) or unsolicited
      assert_idle_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !busy_o) |=> err_flag_o);
      assert_repeat_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && wreq && !ack_i && !err_flag_o) |=> (err_flag_o && err_code_o == 3'd3));
      assert_busy_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && wreq && !ack_i) |=> busy_o);
      assert_busy_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ack_i && !wreq) |=> !busy_o);
    end
  endgenerate

endmodule

bind hsmon_top hsmon_chk #(.KIND(KIND)) u_chk (.*);

// File: tb/sim_hsmon_top.sv
module sim_hsmon_top;
  import hsmon_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // stimulus bits: {req, req0, req1, ack, ack0, ack1, rd}
  logic [6:0] st   [3];
  logic       busy [3];
  logic       err  [3];
  logic [2:0] code [3];

  hsmon_top #(.KIND(CH_CTRL)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(st[0][6]), .req0_i(st[0][5]), .req1_i(st[0][4]), .ack_i(st[0][3]),
    .ack0_i(st[0][2]), .ack1_i(st[0][1]), .rd_i(st[0][0]),
    .busy_o(busy[0]), .err_flag_o(err[0]), .err_code_o(code[0]));
  hsmon_top #(.KIND(CH_READ)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(st[1][6]), .req0_i(st[1][5]), .req1_i(st[1][4]), .ack_i(st[1][3]),
    .ack0_i(st[1][2]), .ack1_i(st[1][1]), .rd_i(st[1][0]),
    .busy_o(busy[1]), .err_flag_o(err[1]), .err_code_o(code[1]));
  hsmon_top #(.KIND(CH_WRITE)) u2 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(st[2][6]), .req0_i(st[2][5]), .req1_i(st[2][4]), .ack_i(st[2][3]),
    .ack0_i(st[2][2]), .ack1_i(st[2][1]), .rd_i(st[2][0]),
    .busy_o(busy[2]), .err_flag_o(err[2]), .err_code_o(code[2]));

  // {target 0=ctrl 1=read 2=write, cycle0, cycle1, busy, err, code}
  localparam int NV = 21;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 7'b1000000, 7'b0000000, 1'b1, 1'b0, 3'd0},
    {2'd0, 7'b1000000, 7'b0001000, 1'b0, 1'b0, 3'd0},
    {2'd0, 7'b1001000, 7'b0000000, 1'b0, 1'b1, 3'd1},
    {2'd0, 7'b0001000, 7'b0000000, 1'b0, 1'b1, 3'd2},
    {2'd0, 7'b1000000, 7'b1000000, 1'b1, 1'b1, 3'd3},
    {2'd0, 7'b1000000, 7'b1001000, 1'b1, 1'b0, 3'd0},
    {2'd0, 7'b0110111, 7'b0110111, 1'b0, 1'b0, 3'd0},
    {2'd1, 7'b1000100, 7'b1000010, 1'b0, 1'b0, 3'd0},
    {2'd1, 7'b1000110, 7'b0000000, 1'b0, 1'b1, 3'd4},
    {2'd1, 7'b1000000, 7'b0000000, 1'b0, 1'b1, 3'd6},
    {2'd1, 7'b0000010, 7'b0000000, 1'b0, 1'b1, 3'd2},
    {2'd2, 7'b0100000, 7'b0001000, 1'b0, 1'b0, 3'd0},
    {2'd2, 7'b0110000, 7'b0000000, 1'b1, 1'b1, 3'd4},
    {2'd2, 7'b0010000, 7'b0001001, 1'b0, 1'b1, 3'd5},
    {2'd2, 7'b0101000, 7'b0000000, 1'b0, 1'b1, 3'd1},
    {2'd2, 7'b0001000, 7'b0000000, 1'b0, 1'b1, 3'd2},
    {2'd2, 7'b0100000, 7'b0010000, 1'b1, 1'b1, 3'd3},
    {2'd0, 7'b1001000, 7'b0001000, 1'b0, 1'b1, 3'd1},
    {2'd1, 7'b0000110, 7'b0000000, 1'b0, 1'b1, 3'd2},
    {2'd1, 7'b1011101, 7'b0000000, 1'b0, 1'b0, 3'd0},
    {2'd2, 7'b1000110, 7'b0000000, 1'b0, 1'b0, 3'd0}
  };
  string VTAG [NV] = '{"R5", "R11", "R2", "R3", "R4", "R5", "R10", "R6", "R6",
                       "R6", "R3", "R11", "R7", "R8", "R2", "R3", "R4", "R9",
                       "R9", "R10", "R10"};

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) st[k] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(input int t, input logic [6:0] v);
    st[t] = v;
    @(negedge clk);
    st[t] = '0;
  endtask

  initial begin
    for (int k = 0; k < 3; k++) st[k] = '0;
    do_reset();

    // reset state of every channel kind
    for (int k = 0; k < 3; k++) begin
      check($sformatf("R1 inst%0d busy", k), int'(busy[k]), 0);
      check($sformatf("R1 inst%0d flag", k), int'(err[k]), 0);
      check($sformatf("R1 inst%0d code", k), int'(code[k]), 0);
    end

    // table walk: two stimulus cycles, outputs sampled one cycle later
    for (int i = 0; i < NV; i++) begin
      int t;
      do_reset();
      t = int'(VEC[i][20:19]);
      st[t] = VEC[i][18:12];
      @(negedge clk);
      st[t] = VEC[i][11:5];
      @(negedge clk);
      st[t] = '0;
      #1;
      check($sformatf("%s vec%0d busy", VTAG[i], i), int'(busy[t]), int'(VEC[i][4]));
      check($sformatf("%s vec%0d flag", VTAG[i], i), int'(err[t]), int'(VEC[i][3]));
      check($sformatf("%s vec%0d code", VTAG[i], i), int'(code[t]), int'(VEC[i][2:0]));
    end

    // R9: first code survives legal traffic and a later, smaller-coded error
    do_reset();
    step(0, 7'b0001000);
    for (int j = 0; j < 4; j++) begin
      step(0, 7'b1000000);
      step(0, 7'b0001000);
    end
    step(0, 7'b1001000);
    step(0, 7'b0000000);
    check("R9 sticky flag", int'(err[0]), 1);
    check("R9 first code held", int'(code[0]), 2);

    // R1: asynchronous reset clears the latched error
    rst_n = 1'b0;
    #2;
    check("R1 async clear flag", int'(err[0]), 0);
    check("R1 async clear code", int'(code[0]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: long legal control and read traffic
    for (int j = 0; j < 5; j++) begin
      step(0, 7'b1000000);
      step(1, 7'b1000100);
      step(0, 7'b1001000);
      step(1, 7'b1000010);
      step(0, 7'b0001000);
    end
    check("R11 ctrl clean", int'(err[0]), 0);
    check("R11 read clean", int'(err[1]), 0);
    check("R5 ctrl idle after run", int'(busy[0]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule